// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects an internal request port to one external asynchronous static RAM of 512K words by 16 bits. The RAM has separate upper and lower byte strobes. A requester offers a word address, a read/write flag, a two-bit byte mask and write data under a valid/ready handshake. For each request the controller runs one timed memory cycle on active-low chip select, write enable, output enable and the two byte strobes. The data bus to the RAM is split into an output word, an output-enable and an input word.

A write holds write enable low for a fixed count of clock cycles. Write enable then rises while address, data, strobes and chip select stay put for one more cycle, so the memory latches the data on the rising edge of write enable. A read holds chip select, output enable and the selected strobes low for a fixed count. It samples the input word on the last of those cycles, returns it with unselected lanes cleared, and then passes through one quiet turnaround cycle. A request whose byte mask is all zero is accepted and answered at once, and no memory cycle is run. With a 100 MHz clock the default counts cover the access and cycle time of the fastest speed grade.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While synchronous reset is high and in the cycle after it, chip select, write enable, output enable and both byte strobes are high, the data-output enable is low, read-valid is low and ready is high.
- R2: Mask bit 0 selects data bits 7:0 and drives the lower strobe low. Mask bit 1 selects bits 15:8 and drives the upper strobe low. This holds for the whole cycle of both reads and writes. Whenever chip select is low, at least one strobe is low.
- R3: A write accepted at clock edge E0 drives write enable low, and puts the data on the bus with the output enable high, from E0 to E5. Write enable rises at E5. Chip select, strobes, address and data stay unchanged until E6, when everything is released and ready returns high.
- R4: A read accepted at E0 drives chip select and output enable low, with write enable high, from E0 to E6. The input word is sampled at E6, and read-valid is high for the one cycle after E6.
- R5: Ready is high only when no memory cycle is in progress, and chip select, write enable and output enable are all high while ready is high.
- R6: The data-output enable is never high while output enable is low.
- R7: After a read, output enable rises at E6 and ready stays low for one more cycle. The earliest next request is accepted at E8, so the bus gets a full cycle of turnaround before any write drives it.
- R8: A request with mask 00 is accepted without any change on chip select. A read with mask 00 returns read-valid in the next cycle with data 0, and a write with mask 00 changes no memory contents.
- R9: Read data has the byte lanes that were not selected forced to zero.
- R10: The 19-bit word address is driven on the memory address bus, unchanged, for the whole memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_addr | input | 19 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Byte select, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory word address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
The hardest case to reach from the ports is a read sampled too early, because a memory model that returns data at once would hide it. The bench memory returns a junk word until the read conditions have held for six cycles, and it returns a fixed junk byte on any lane whose strobe is high. A wrong sample point or a missing lane clear therefore shows up in the read data. Random traffic runs over a small pool of addresses that includes both ends of the range, so reads often land on words that earlier partial writes have modified. Reads followed at once by writes exercise the turnaround cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_LOW,
    ST_WR_HOLD,
    ST_TURN
  } ctrl_state_t;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit);
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   sel,
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*8 +: 8] = sel[g] ? din[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int RD_CYC   = 6,
  parameter int WE_CYC   = 5,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W/8-1:0] req_mask,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);
  localparam int LANES = DATA_W / 8;
  localparam int MAX_A = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAX_B = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  ctrl_state_t       st, st_nx;
  logic [LANES-1:0]  strb_n;
  logic [CW-1:0]     tmr_limit;
  logic              tmr_done;
  logic              tmr_clear;
  logic              accept;
  logic              mask_zero;
  logic [DATA_W-1:0] rd_gated;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_zero = (req_mask == '0);
  assign mem_lb_n  = strb_n[0];
  assign mem_ub_n  = strb_n[LANES-1];

  always_comb begin
    st_nx     = st;
    tmr_limit = '0;
    case (st)
      ST_IDLE: begin
        if (accept && !mask_zero) st_nx = req_write ? ST_WR_LOW : ST_RD;
      end
      ST_RD: begin
        tmr_limit = CW'(RD_CYC - 1);
        if (tmr_done) st_nx = ST_TURN;
      end
      ST_WR_LOW: begin
        tmr_limit = CW'(WE_CYC - 1);
        if (tmr_done) st_nx = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        tmr_limit = CW'(HOLD_CYC - 1);
        if (tmr_done) st_nx = ST_IDLE;
      end
      ST_TURN: begin
        tmr_limit = CW'(TURN_CYC - 1);
        if (tmr_done) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign tmr_clear = (st_nx != st) || (st == ST_IDLE);

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  sram_lane_gate #(.LANES(LANES)) u_gate (
    .sel  (~strb_n),
    .din  (mem_dq_in),
    .dout (rd_gated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      strb_n     <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st        <= st_nx;
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (mask_zero) begin
              rsp_valid <= !req_write;
              rsp_rdata <= '0;
            end else begin
              mem_addr <= req_addr;
              mem_cs_n <= 1'b0;
              strb_n   <= ~req_mask;
              if (req_write) begin
                mem_we_n   <= 1'b0;
                mem_dq_out <= req_wdata;
                mem_dq_oe  <= 1'b1;
              end else begin
                mem_oe_n <= 1'b0;
              end
            end
          end
        end
        ST_RD: begin
          if (tmr_done) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_gated;
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            strb_n    <= '1;
          end
        end
        ST_WR_LOW: begin
          if (tmr_done) mem_we_n <= 1'b1;
        end
        ST_WR_HOLD: begin
          if (tmr_done) begin
            mem_cs_n  <= 1'b1;
            strb_n    <= '1;
            mem_dq_oe <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)) else $error("bus contention"); // R6
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe)) else $error("write enable without select"); // R3
  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)))
    else $error("data not held across write enable rise"); // R3
  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n)) else $error("read with write enable low"); // R4
  AST_CS_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !(mem_lb_n && mem_ub_n)) else $error("select without any lane"); // R2
  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n)) else $error("idle not parked"); // R5
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe) else $error("no turnaround"); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)) else $error("address moved"); // R10
endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mask = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = 16'hDEAD;

  int nchk = 0;
  int nfail = 0;
  int contention = 0;
  int age = 0;
  logic [15:0] model [int];
  logic [15:0] refm  [int];

  always #10 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_mask(req_mask),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [15:0] rd_word(input logic [15:0] arr [int], input int a);
    return arr.exists(a) ? arr[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
  endfunction

  // memory model: data valid only after six cycles of read conditions
  always @(negedge clk) begin
    if (!rst && !mem_cs_n && !mem_oe_n && mem_we_n && !(mem_lb_n && mem_ub_n)) age++;
    else age = 0;
    if (age >= 6) begin
      logic [15:0] w;
      w = rd_word(model, int'(mem_addr));
      mem_dq_in = {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'hA5 : w[7:0]};
    end else mem_dq_in = 16'hDEAD;
    if (!rst && mem_dq_oe && !mem_oe_n) contention++;
  end

  always @(posedge mem_we_n) begin
    if (!rst && !mem_cs_n)
      model[int'(mem_addr)] = merge(rd_word(model, int'(mem_addr)), mem_dq_out,
                                    ~{mem_ub_n, mem_lb_n});
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ctl vector: {cs_n, we_n, oe_n, dq_oe, ready, rsp_valid}
  task automatic do_req(input bit wr, input logic [18:0] a, input logic [1:0] m,
                        input logic [15:0] d);
    logic [5:0] ctl_exp, ctl_bad_a, ctl_bad_e;
    logic [1:0] sb_exp, sb_bad;
    bit ctl_ok, sb_ok, adr_ok, dat_ok;
    logic [15:0] exp_rd;
    exp_rd = lanes(rd_word(refm, int'(a)), m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
    ctl_ok = 1; sb_ok = 1; adr_ok = 1; dat_ok = 1;
    ctl_bad_a = '0; ctl_bad_e = '0; sb_bad = '0;
    if (m == 2'b00) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_cs_n && req_ready, "R8 no cycle on zero mask", {30'd0, mem_cs_n, req_ready}, 32'd3);
      chk(rsp_valid == !wr, "R8 zero-mask response", {31'd0, rsp_valid}, {31'd0, !wr});
      if (!wr) chk(rsp_rdata == 16'h0, "R8 zero-mask data", {16'd0, rsp_rdata}, 32'd0);
      return;
    end
    for (int n = 1; n <= (wr ? 7 : 8); n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      sb_exp = 2'b11;
      if (wr) begin
        if (n <= 5)      begin ctl_exp = 6'b001100; sb_exp = ~m; end
        else if (n == 6) begin ctl_exp = 6'b011100; sb_exp = ~m; end
        else               ctl_exp = 6'b111010;
      end else begin
        if (n <= 6)      begin ctl_exp = 6'b010000; sb_exp = ~m; end
        else if (n == 7)   ctl_exp = 6'b111001;
        else               ctl_exp = 6'b111010;
      end
      if ({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} !== ctl_exp && ctl_ok) begin
        ctl_ok = 0; ctl_bad_e = ctl_exp;
        ctl_bad_a = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid};
      end
      if ({mem_ub_n, mem_lb_n} !== sb_exp && sb_ok) begin
        sb_ok = 0; sb_bad = {mem_ub_n, mem_lb_n};
      end
      if (n <= 6 && mem_addr !== a) adr_ok = 0;
      if (wr && n <= 6 && mem_dq_out !== d) dat_ok = 0;
      if (!wr && n == 7) begin
        chk(req_ready == 1'b0, "R7 turnaround cycle", {31'd0, req_ready}, 32'd0);
        chk(rsp_rdata == exp_rd, (m == 2'b11) ? "R4 read data" : "R9 lane clear",
            {16'd0, rsp_rdata}, {16'd0, exp_rd});
      end
    end
    chk(ctl_ok, wr ? "R3 write sequence" : "R4 read sequence", {26'd0, ctl_bad_a}, {26'd0, ctl_bad_e});
    chk(sb_ok, "R2 byte strobes", {30'd0, sb_bad}, {30'd0, ~m});
    chk(adr_ok, "R10 address held", {13'd0, mem_addr}, {13'd0, a});
    if (wr) begin
      chk(dat_ok, "R3 write data held", {16'd0, mem_dq_out}, {16'd0, d});
      refm[int'(a)] = merge(rd_word(refm, int'(a)), d, m);
    end
  endtask

  logic [18:0] pool [8];

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd91));
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00001; pool[3] = 19'h40000;
    pool[4] = 19'h12345; pool[5] = 19'h3FFFF; pool[6] = 19'h00FF0; pool[7] = 19'h55555;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
        "R1 state in reset", {24'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid},
        32'hFA);
    rst = 1'b0;
    @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid} == 8'b11111010,
        "R1 state after reset", {24'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready, rsp_valid},
        32'hFA);

    // directed corners
    do_req(1, 19'h7FFFF, 2'b11, 16'hBEEF);
    do_req(0, 19'h7FFFF, 2'b11, 16'h0);
    do_req(1, 19'h7FFFF, 2'b01, 16'h1234);
    do_req(0, 19'h7FFFF, 2'b10, 16'h0);
    do_req(0, 19'h7FFFF, 2'b01, 16'h0);
    do_req(1, 19'h00000, 2'b10, 16'hCAFE);
    do_req(1, 19'h00000, 2'b00, 16'hFFFF);
    do_req(0, 19'h00000, 2'b00, 16'h0);
    do_req(0, 19'h00000, 2'b11, 16'h0);
    do_req(1, 19'h00000, 2'b11, 16'h0F0F);
    repeat (3) begin
      @(negedge clk);
      chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n, "R5 idle parked",
          {28'd0, req_ready, mem_cs_n, mem_we_n, mem_oe_n}, 32'hF);
    end

    for (int i = 0; i < 150; i++) begin
      do_req(1'($urandom_range(1)), pool[$urandom_range(7)], 2'($urandom_range(3)),
             16'($urandom));
    end

    for (int i = 0; i < 8; i++) do_req(0, pool[i], 2'b11, 16'h0);

    chk(contention == 0, "R6 no drive while memory outputs on", contention, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule